// File: doc/BRIEF.md
# NTSC Interlaced Raster Timing Generator

This block is the timing master for an interlaced 525-line raster. It runs from a pixel clock of either 27 MHz or 24.54 MHz (square pixel), keeps a pixel counter and a line counter, and drives horizontal sync, vertical sync and a field indicator. A separate blank flag tells the downstream datapath when to ignore incoming pixels and send a fixed blanking level.

The horizontal sync pin can carry a composite blanking strobe instead of sync. The active level of each sync pin is set by its own polarity input. The field indicator can report odd/even parity or the two-frame, four-field sequence. Field parity is encoded in the phase between the sync edges. At an odd field start the vertical and horizontal active edges coincide. At an even field start vertical sync goes active in the middle of a line, while horizontal sync is idle.

All configuration inputs are expected to be held steady while reset is low. A change of configuration is made under reset.

Top module: `ntsc_raster_tg`

## Requirements
- R1: While `rst` is high, `hsync_o` and `vsync_o` sit at their inactive levels and `field_o`=1 and `blank_o`=0. The inactive level is 1 when the matching act-low input is 1, else 0. The outputs are registered, so the first rising edge after reset releases presents pixel 0 of line 4. At that point horizontal and vertical sync are both active, `field_o`=1 and `blank_o`=1.
- R2: With `cfg_sq_pixel`=0 a line lasts LINE_27 clocks, and with `cfg_sq_pixel`=1 it lasts LINE_SQ clocks. A frame holds lines 1 to 525, so successive vertical sync active edges are 525·L/2 clocks apart, where L is the line length.
- R3: With composite blanking off, horizontal sync is active during pixels 0 to HSYNC_W-1 of every line. Its active level is 0 when `cfg_hs_act_low`=1 and 1 when it is 0.
- R4: An odd field starts at pixel 0 of line 4. Vertical sync goes active on that same clock as horizontal sync and stays active for exactly 3 lines.
- R5: An even field starts at pixel L/2 of line 266, while horizontal sync is inactive. Vertical sync stays active for exactly 3 lines, to pixel L/2 of line 269. Its active level is 0 when `cfg_vs_act_low`=1 and 1 when it is 0.
- R6: With `cfg_field_analog`=0, `field_o` is 1 from pixel 0 of line 4 up to pixel L/2-1 of line 266, and 0 for the rest of the frame.
- R7: With `cfg_field_analog`=1, `field_o` is 1 for the whole first frame after reset, which holds fields 1 and 2. It is 0 for the following frame, which holds fields 3 and 4. It then alternates every frame, changing at pixel 0 of line 4.
- R8: With `cfg_cblank_en`=1, `hsync_o` follows the blank flag. It is 0 on blanked pixels when `cfg_hs_act_low`=1 and 1 on blanked pixels when it is 0. On all other pixels it takes the opposite level.
- R9: `blank_o` is 1 when either of two conditions holds:
  - the pixel index is below the horizontal blanking length for the selected rate (HBLANK_27 or HBLANK_SQ);
  - the line lies in 1..VBL_ODD_LAST or in VBL_EVEN_FIRST..VBL_EVEN_LAST.

  This holds whether or not composite blanking is enabled.
- R10: The `vsync_o` and `field_o` sequences are identical with `cfg_cblank_en`=0 and with `cfg_cblank_en`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock; all outputs change on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sq_pixel | input | 1 | 0: 27 MHz line length, 1: square-pixel line length |
| cfg_hs_act_low | input | 1 | 1: horizontal sync (or blank strobe) active level is 0 |
| cfg_vs_act_low | input | 1 | 1: vertical sync active level is 0 |
| cfg_cblank_en | input | 1 | 1: horizontal sync pin carries composite blanking |
| cfg_field_analog | input | 1 | 0: odd/even field indicator, 1: four-field frame-pair indicator |
| hsync_o | output | 1 | Horizontal sync or composite blanking strobe |
| vsync_o | output | 1 | Vertical sync |
| field_o | output | 1 | Field indicator |
| blank_o | output | 1 | High when pixel input must be ignored and blanking level sent |

## Verification
The assertions check several behaviours on every cycle:
- the pixel counter wraps at the line length of the selected rate, and the line counter wraps from 525 to 1;
- every vertical sync pulse lasts three lines;
- the field indicator changes only on a vertical sync active edge;
- at the start of a field the phase of horizontal sync matches the field parity;
- the composite strobe agrees with the blank flag.

Only the bench scenarios can show the absolute positions of the odd and even field starts, the blanking ranges and the four-field alternation over two frames. They also show that vertical sync and field come out the same whether the composite strobe is on or off.

// File: rtl/ntsc_tg_pkg.sv
package ntsc_tg_pkg;

    // Raster geometry fixed by the 525-line interlaced standard
    localparam int LINE_W          = 10;
    localparam int FRAME_LINES     = 525;
    localparam int ODD_START_LINE  = 4;
    localparam int EVEN_START_LINE = 266;
    localparam int VS_LINES        = 3;

    // Half-line index: (line-1)*2 + second_half
    localparam int HL_W       = LINE_W + 1;
    localparam int ODD_VS_HL  = (ODD_START_LINE - 1) * 2;
    localparam int EVEN_VS_HL = (EVEN_START_LINE - 1) * 2 + 1;
    localparam int VS_HLEN    = VS_LINES * 2;

    typedef enum logic {
        RATE_CCIR  = 1'b0,
        RATE_SQPIX = 1'b1
    } pix_rate_e;

    typedef enum logic {
        FLDMODE_PARITY    = 1'b0,
        FLDMODE_FOURFIELD = 1'b1
    } fld_mode_e;

    typedef struct packed {
        pix_rate_e rate;
        logic      hs_act_low;
        logic      vs_act_low;
        logic      cblank_en;
        fld_mode_e fld_mode;
    } tg_cfg_t;

    typedef struct packed {
        logic hs;
        logic hbl;
        logic second_half;
        logic eol;
    } hpos_t;

    typedef struct packed {
        logic vs;
        logic vbl;
        logic odd;
        logic frame_a;
    } vpos_t;

    function automatic logic in_window(logic [HL_W-1:0] v, int first, int len);
        return (int'(v) >= first) && (int'(v) < first + len);
    endfunction

    function automatic logic pin_level(logic active, logic act_low);
        return active ^ act_low;
    endfunction

endpackage

// File: rtl/ntsc_tg_hcount.sv
module ntsc_tg_hcount
    import ntsc_tg_pkg::*;
#(
    parameter int LINE_27   = 858,
    parameter int LINE_SQ   = 780,
    parameter int HSYNC_W   = 64,
    parameter int HBLANK_27 = 138,
    parameter int HBLANK_SQ = 126,
    parameter int HW        = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  pix_rate_e     rate,
    output logic [HW-1:0] h_cnt,
    output hpos_t         hpos
);

    localparam logic [HW-1:0] LAST_27 = HW'(LINE_27 - 1);
    localparam logic [HW-1:0] LAST_SQ = HW'(LINE_SQ - 1);
    localparam logic [HW-1:0] HALF_27 = HW'(LINE_27 / 2);
    localparam logic [HW-1:0] HALF_SQ = HW'(LINE_SQ / 2);
    localparam logic [HW-1:0] HBL_27  = HW'(HBLANK_27);
    localparam logic [HW-1:0] HBL_SQ  = HW'(HBLANK_SQ);
    localparam logic [HW-1:0] HSW     = HW'(HSYNC_W);

    logic [HW-1:0] last_px;
    logic [HW-1:0] half_px;
    logic [HW-1:0] hbl_len;
    logic [HW-1:0] cnt_q;

    always_comb begin
        if (rate == RATE_SQPIX) begin
            last_px = LAST_SQ;
            half_px = HALF_SQ;
            hbl_len = HBL_SQ;
        end else begin
            last_px = LAST_27;
            half_px = HALF_27;
            hbl_len = HBL_27;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q >= last_px) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        hpos.eol         = (cnt_q >= last_px);
        hpos.second_half = (cnt_q >= half_px);
        hpos.hs          = (cnt_q < HSW);
        hpos.hbl         = (cnt_q < hbl_len);
    end

    assign h_cnt = cnt_q;

endmodule

// File: rtl/ntsc_tg_vcount.sv
module ntsc_tg_vcount
    import ntsc_tg_pkg::*;
#(
    parameter int VBL_ODD_LAST   = 21,
    parameter int VBL_EVEN_FIRST = 264,
    parameter int VBL_EVEN_LAST  = 283
) (
    input  logic              clk,
    input  logic              rst,
    input  hpos_t             hpos,
    output logic [LINE_W-1:0] line_cnt,
    output vpos_t             vpos
);

    localparam logic [LINE_W-1:0] LAST_LINE  = LINE_W'(FRAME_LINES);
    localparam logic [LINE_W-1:0] RESET_LINE = LINE_W'(ODD_START_LINE);
    localparam logic [LINE_W-1:0] PRE_ODD    = LINE_W'(ODD_START_LINE - 1);

    logic [LINE_W-1:0] line_q;
    logic              frame_a_q;
    logic [HL_W-1:0]   hl_idx;

    // Line counter: advances on the last pixel of each line, 525 -> 1
    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= RESET_LINE;
        end else if (hpos.eol) begin
            if (line_q == LAST_LINE) begin
                line_q <= LINE_W'(1);
            end else begin
                line_q <= line_q + 1'b1;
            end
        end
    end

    // Frame-pair phase: toggles as the raster enters line 4
    always_ff @(posedge clk) begin
        if (rst) begin
            frame_a_q <= 1'b1;
        end else if (hpos.eol && (line_q == PRE_ODD)) begin
            frame_a_q <= ~frame_a_q;
        end
    end

    assign hl_idx = {line_q - 1'b1, hpos.second_half};

    always_comb begin
        vpos.vs = in_window(hl_idx, ODD_VS_HL, VS_HLEN) ||
                  in_window(hl_idx, EVEN_VS_HL, VS_HLEN);
        vpos.odd = in_window(hl_idx, ODD_VS_HL, EVEN_VS_HL - ODD_VS_HL);
        vpos.vbl = (int'(line_q) <= VBL_ODD_LAST) ||
                   ((int'(line_q) >= VBL_EVEN_FIRST) && (int'(line_q) <= VBL_EVEN_LAST));
        vpos.frame_a = frame_a_q;
    end

    assign line_cnt = line_q;

endmodule

// File: rtl/ntsc_tg_outstage.sv
module ntsc_tg_outstage
    import ntsc_tg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  tg_cfg_t cfg,
    input  hpos_t   hpos,
    input  vpos_t   vpos,
    output logic    hsync_o,
    output logic    vsync_o,
    output logic    field_o,
    output logic    blank_o
);

    logic blank_now;
    logic hpin_active;
    logic field_now;

    always_comb begin
        blank_now   = hpos.hbl | vpos.vbl;
        hpin_active = cfg.cblank_en ? blank_now : hpos.hs;
        field_now   = (cfg.fld_mode == FLDMODE_FOURFIELD) ? vpos.frame_a : vpos.odd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hsync_o <= cfg.hs_act_low;
            vsync_o <= cfg.vs_act_low;
            field_o <= 1'b1;
            blank_o <= 1'b0;
        end else begin
            hsync_o <= pin_level(hpin_active, cfg.hs_act_low);
            vsync_o <= pin_level(vpos.vs, cfg.vs_act_low);
            field_o <= field_now;
            blank_o <= blank_now;
        end
    end

endmodule

// File: rtl/ntsc_raster_tg.sv
module ntsc_raster_tg
    import ntsc_tg_pkg::*;
#(
    parameter int LINE_27        = 858,
    parameter int LINE_SQ        = 780,
    parameter int HSYNC_W        = 64,
    parameter int HBLANK_27      = 138,
    parameter int HBLANK_SQ      = 126,
    parameter int VBL_ODD_LAST   = 21,
    parameter int VBL_EVEN_FIRST = 264,
    parameter int VBL_EVEN_LAST  = 283
) (
    input  logic clk,
    input  logic rst,
    input  logic cfg_sq_pixel,
    input  logic cfg_hs_act_low,
    input  logic cfg_vs_act_low,
    input  logic cfg_cblank_en,
    input  logic cfg_field_analog,
    output logic hsync_o,
    output logic vsync_o,
    output logic field_o,
    output logic blank_o
);

    localparam int LINE_MAX = (LINE_27 > LINE_SQ) ? LINE_27 : LINE_SQ;
    localparam int HW       = $clog2(LINE_MAX);

    tg_cfg_t           cfg;
    hpos_t             hpos;
    vpos_t             vpos;
    logic [HW-1:0]     h_cnt;
    logic [LINE_W-1:0] line_cnt;

    always_comb begin
        cfg.rate       = pix_rate_e'(cfg_sq_pixel);
        cfg.hs_act_low = cfg_hs_act_low;
        cfg.vs_act_low = cfg_vs_act_low;
        cfg.cblank_en  = cfg_cblank_en;
        cfg.fld_mode   = fld_mode_e'(cfg_field_analog);
    end

    ntsc_tg_hcount #(
        .LINE_27  (LINE_27),
        .LINE_SQ  (LINE_SQ),
        .HSYNC_W  (HSYNC_W),
        .HBLANK_27(HBLANK_27),
        .HBLANK_SQ(HBLANK_SQ),
        .HW       (HW)
    ) u_hcount (
        .clk  (clk),
        .rst  (rst),
        .rate (cfg.rate),
        .h_cnt(h_cnt),
        .hpos (hpos)
    );

    ntsc_tg_vcount #(
        .VBL_ODD_LAST  (VBL_ODD_LAST),
        .VBL_EVEN_FIRST(VBL_EVEN_FIRST),
        .VBL_EVEN_LAST (VBL_EVEN_LAST)
    ) u_vcount (
        .clk     (clk),
        .rst     (rst),
        .hpos    (hpos),
        .line_cnt(line_cnt),
        .vpos    (vpos)
    );

    ntsc_tg_outstage u_out (
        .clk    (clk),
        .rst    (rst),
        .cfg    (cfg),
        .hpos   (hpos),
        .vpos   (vpos),
        .hsync_o(hsync_o),
        .vsync_o(vsync_o),
        .field_o(field_o),
        .blank_o(blank_o)
    );

endmodule

// File: rtl/ntsc_raster_tg_chk.sv
module ntsc_raster_tg_chk #(
    parameter int LINE_27 = 858,
    parameter int LINE_SQ = 780,
    parameter int HW      = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_sq_pixel,
    input logic          cfg_hs_act_low,
    input logic          cfg_vs_act_low,
    input logic          cfg_cblank_en,
    input logic          cfg_field_analog,
    input logic          hsync_o,
    input logic          vsync_o,
    input logic          field_o,
    input logic          blank_o,
    input logic [HW-1:0] h_cnt,
    input logic [9:0]    line_cnt
);

    int   line_len;
    int   vs_run;
    logic vs_act;
    logic hs_act;

    assign line_len = cfg_sq_pixel ? LINE_SQ : LINE_27;
    assign vs_act   = vsync_o ^ cfg_vs_act_low;
    assign hs_act   = hsync_o ^ cfg_hs_act_low;

    // Length of the current vertical sync pulse in clocks
    always_ff @(posedge clk) begin
        if (rst) begin
            vs_run <= 0;
        end else if (vs_act) begin
            vs_run <= vs_run + 1;
        end else begin
            vs_run <= 0;
        end
    end

    p_hwrap_r2: assert property (@(posedge clk) disable iff (rst)
        (int'(h_cnt) == line_len - 1) |=> (h_cnt == '0));

    p_frame_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        ((int'(h_cnt) == line_len - 1) && (line_cnt == 10'd525)) |=> (line_cnt == 10'd1));

    p_vs_len_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(vs_act) |-> (vs_run == 3 * line_len));

    p_field_phase_r5: assert property (@(posedge clk) disable iff (rst)
        (!cfg_field_analog && !cfg_cblank_en && $rose(vs_act)) |-> (hs_act == field_o));

    p_field_edge_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(field_o) |-> $rose(vs_act));

    p_cblank_level_r8: assert property (@(posedge clk) disable iff (rst)
        cfg_cblank_en |-> (hsync_o == (blank_o ^ cfg_hs_act_low)));

    p_sync_in_blank_r9: assert property (@(posedge clk) disable iff (rst)
        (!cfg_cblank_en && hs_act) |-> blank_o);

endmodule

bind ntsc_raster_tg ntsc_raster_tg_chk #(
    .LINE_27(LINE_27),
    .LINE_SQ(LINE_SQ),
    .HW     (HW)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .cfg_sq_pixel    (cfg_sq_pixel),
    .cfg_hs_act_low  (cfg_hs_act_low),
    .cfg_vs_act_low  (cfg_vs_act_low),
    .cfg_cblank_en   (cfg_cblank_en),
    .cfg_field_analog(cfg_field_analog),
    .hsync_o         (hsync_o),
    .vsync_o         (vsync_o),
    .field_o         (field_o),
    .blank_o         (blank_o),
    .h_cnt           (h_cnt),
    .line_cnt        (line_cnt)
);

// File: tb/ntsc_raster_tg_bench.sv
module ntsc_raster_tg_bench;

    localparam int CLK_PERIOD = 10;
    localparam int L27  = 40;
    localparam int LSQ  = 32;
    localparam int HSW  = 4;
    localparam int HB27 = 10;
    localparam int HBSQ = 8;
    localparam int VBO  = 21;
    localparam int VBEF = 264;
    localparam int VBEL = 283;
    localparam int WATCHDOG = 190000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic c_sq = 1'b0;
    logic c_hl = 1'b0;
    logic c_vl = 1'b0;
    logic c_cb = 1'b0;
    logic c_an = 1'b0;
    logic hsync_o, vsync_o, field_o, blank_o;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ntsc_raster_tg #(
        .LINE_27       (L27),
        .LINE_SQ       (LSQ),
        .HSYNC_W       (HSW),
        .HBLANK_27     (HB27),
        .HBLANK_SQ     (HBSQ),
        .VBL_ODD_LAST  (VBO),
        .VBL_EVEN_FIRST(VBEF),
        .VBL_EVEN_LAST (VBEL)
    ) u_ntsc_raster_tg (
        .clk             (clk),
        .rst             (rst),
        .cfg_sq_pixel    (c_sq),
        .cfg_hs_act_low  (c_hl),
        .cfg_vs_act_low  (c_vl),
        .cfg_cblank_en   (c_cb),
        .cfg_field_analog(c_an),
        .hsync_o         (hsync_o),
        .vsync_o         (vsync_o),
        .field_o         (field_o),
        .blank_o         (blank_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_scn(input bit sq, input bit hl, input bit vl, input bit cb,
                           input bit an, input int nframes, output int sig);
        int L, H, HB, n;
        int ml, mh, ph;
        int e_hs, e_vs, e_fld, e_blk, e_blank, e_odd, e_hact, e_vact;
        int err[4];
        int fa[4];
        int fe[4];
        int prev_h, prev_v, last_h, last_v, cyc;
        int len_err, len_act, vlen_err, vlen_act;
        L  = sq ? LSQ : L27;
        H  = L / 2;
        HB = sq ? HBSQ : HB27;
        n  = nframes * 525 * L + 5;
        @(negedge clk);
        rst = 1'b1;
        c_sq = sq; c_hl = hl; c_vl = vl; c_cb = cb; c_an = an;
        repeat (3) @(negedge clk);
        check(hsync_o == hl, "R1", "reset hsync", hsync_o, hl);
        check(vsync_o == vl, "R1", "reset vsync", vsync_o, vl);
        check(field_o == 1'b1, "R1", "reset field", field_o, 1);
        check(blank_o == 1'b0, "R1", "reset blank", blank_o, 0);
        ml = 4; mh = 0; ph = 1; sig = 0;
        for (int i = 0; i < 4; i++) begin err[i] = 0; fa[i] = 0; fe[i] = 0; end
        prev_h = 0; prev_v = 0; last_h = -1; last_v = -1;
        len_err = 0; len_act = 0; vlen_err = 0; vlen_act = 0;
        rst = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cyc = k;
            e_hact  = (mh < HSW) ? 1 : 0;
            e_blank = ((mh < HB) || (ml <= VBO) || (ml >= VBEF && ml <= VBEL)) ? 1 : 0;
            e_vact  = ((ml >= 4 && ml <= 6) || (ml == 266 && mh >= H) ||
                       ml == 267 || ml == 268 || (ml == 269 && mh < H)) ? 1 : 0;
            e_odd   = ((ml >= 4 && ml <= 265) || (ml == 266 && mh < H)) ? 1 : 0;
            e_fld   = an ? ph : e_odd;
            e_hs    = cb ? (e_blank ^ int'(hl)) : (e_hact ^ int'(hl));
            e_vs    = e_vact ^ int'(vl);
            e_blk   = e_blank;
            if (k == 0) begin
                check((hsync_o ^ hl) == 1'b1, "R1", "first edge hsync active", hsync_o, int'(!hl));
                check((vsync_o ^ vl) == 1'b1, "R1", "first edge vsync active", vsync_o, int'(!vl));
                check(field_o == 1'b1, "R1", "first edge field", field_o, 1);
                check(blank_o == 1'b1, "R1", "first edge blank", blank_o, 1);
            end
            if (int'(hsync_o) != e_hs) begin if (err[0] == 0) begin fa[0] = hsync_o; fe[0] = e_hs; end err[0]++; end
            if (int'(vsync_o) != e_vs) begin if (err[1] == 0) begin fa[1] = vsync_o; fe[1] = e_vs; end err[1]++; end
            if (int'(field_o) != e_fld) begin if (err[2] == 0) begin fa[2] = field_o; fe[2] = e_fld; end err[2]++; end
            if (int'(blank_o) != e_blk) begin if (err[3] == 0) begin fa[3] = blank_o; fe[3] = e_blk; end err[3]++; end
            // R2: spacing of sync active edges seen at the pins
            if (!cb && (hsync_o ^ hl) && prev_h == 0) begin
                if (last_h >= 0 && (cyc - last_h) != L) begin len_err++; len_act = cyc - last_h; end
                last_h = cyc;
            end
            if ((vsync_o ^ vl) && prev_v == 0) begin
                if (last_v >= 0 && (cyc - last_v) != 525 * L / 2) begin vlen_err++; vlen_act = cyc - last_v; end
                last_v = cyc;
            end
            prev_h = int'(hsync_o ^ hl);
            prev_v = int'(vsync_o ^ vl);
            sig = sig * 33 + int'({vsync_o, field_o}) + 1;
            // advance the model raster position
            mh++;
            if (mh == L) begin
                mh = 0;
                ml = (ml == 525) ? 1 : ml + 1;
                if (ml == 4) ph = 1 - ph;
            end
        end
        check(err[0] == 0, cb ? "R8" : "R3", "hsync pin sequence", fa[0], fe[0]);
        check(err[1] == 0, "R4 R5", "vsync sequence", fa[1], fe[1]);
        check(err[2] == 0, an ? "R7" : "R6", "field sequence", fa[2], fe[2]);
        check(err[3] == 0, "R9", "blank flag sequence", fa[3], fe[3]);
        check(len_err == 0, "R2", "line length", len_act, L);
        check(vlen_err == 0, "R2", "half-frame spacing", vlen_act, 525 * L / 2);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int sig_a, sig_b, sig_c;
        // 27 MHz, active-high syncs, parity field, no composite strobe
        run_scn(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1, sig_a);
        // same with composite strobe: vsync/field must not change
        run_scn(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1, sig_b);
        check(sig_a == sig_b, "R10", "vsync/field signature with cblank", sig_b, sig_a);
        // square pixel, both active-low, composite strobe, four-field over two frames
        run_scn(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2, sig_c);
        // 27 MHz, hsync active-high, vsync active-low, composite strobe, four-field
        run_scn(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2, sig_c);
        // square pixel, hsync active-low, parity field, no composite strobe
        run_scn(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1, sig_c);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule